// File: doc/BRIEF.md
# Deferred-Commit SRAM Write Buffer

This block sits between a processor-side memory port and a single-port synchronous SRAM. It holds one pending write. A write from the processor is accepted in the cycle it is presented and is parked in the holding entry. The SRAM is not touched until a later write arrives. In that later cycle the parked entry goes out on the SRAM port and the new write takes its place. The processor never waits, so a stream of stores keeps going at one per cycle.

Because data stays parked until the next store, a reset loses the last write. Software that must be sure a value has reached the array issues a throw-away store to a spare address. Reads are served from the SRAM and complete one cycle after the request. When the requested word is the one that is parked, the parked bytes are laid over the SRAM data before the result reaches the processor. Accesses are one, two or four bytes wide. Lanes are little-endian, and the write data is right-justified on the processor side.

Top module: `sram_wbuf`

## Requirements
- R1: After reset the holding entry is empty. The first write after reset raises no SRAM write strobe in its own cycle.
- R2: Size code 0 enables the single lane given by cpu_addr[1:0]. Code 1 enables lanes 1:0 when cpu_addr[1] is 0 and lanes 3:2 when it is 1, and address bit 0 is ignored. Codes 2 and 3 enable all four lanes. The low-order bytes of cpu_wdata are moved up into the enabled lanes.
- R3: A write is never placed on the SRAM port in its own cycle. It is committed, with its word address, lane enables and lane data, in the cycle of the next write.
- R4: Writes presented on consecutive cycles are all accepted. There is no stall signal, and each write commits its predecessor.
- R5: A read drives sram_en high, sram_we low and sram_addr equal to the word address in the same cycle. cpu_rdata is valid on the following cycle.
- R6: A read whose word address matches a valid parked entry returns the parked bytes in the lanes that entry enables, and SRAM data in the other lanes.
- R7: A read of any other word returns the SRAM word unchanged.
- R8: Reset discards the parked write. Its data never reaches the SRAM, and the next write after reset commits nothing.
- R9: In a cycle with no request, sram_en stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_size | input | 2 | Access size code (0 byte, 1 half, 2/3 word) |
| cpu_wdata | input | DATA_W | Right-justified write data |
| cpu_rdata | output | DATA_W | Read data, one cycle after the read |
| sram_en | output | 1 | SRAM access strobe |
| sram_we | output | 1 | SRAM write strobe |
| sram_addr | output | ADDR_W-2 | SRAM word address |
| sram_be | output | DATA_W/8 | SRAM lane enables |
| sram_wdata | output | DATA_W | SRAM write data |
| sram_rdata | input | DATA_W | SRAM read data, one cycle after the strobe |

## Verification
The case that is hardest to reach is a read that hits a partially written word that is still parked. In that case the SRAM holds stale bytes in exactly the lanes that must be replaced. The stimulus preloads the SRAM model with a distinct pattern in every byte, stores single bytes and halfwords, and reads the same word straight away. Forwarded and stale bytes are therefore told apart lane by lane. A reset is applied while a store is parked, and a read of that word afterwards must show the old pattern.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_WIDE  = 2'd3
   } acc_size_e;
endpackage

// File: rtl/wbuf_lane_map.sv
module wbuf_lane_map #(
   parameter int DATA_W = 32
) (
   input  logic [$clog2(DATA_W/8)-1:0] off,
   input  logic [1:0]                  size,
   input  logic [DATA_W-1:0]           wdata,
   output logic [DATA_W/8-1:0]         be,
   output logic [DATA_W-1:0]           lane_data
);
   localparam int LANES = DATA_W / 8;
   localparam int OFF_W = $clog2(LANES);

   logic [OFF_W-1:0] aoff;
   int               nbytes;

   always_comb begin
      int eff;
      eff = (int'(size) > OFF_W) ? OFF_W : int'(size);
      nbytes = 1 << eff;
      aoff = off & OFF_W'(~(nbytes - 1));
      lane_data = wdata << (8 * int'(aoff));
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign be[i] = (i >= int'(aoff)) && (i < int'(aoff) + nbytes);
   end
endmodule

// File: rtl/wbuf_hold.sv
module wbuf_hold #(
   parameter int WA_W  = 8,
   parameter int LANES = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [WA_W-1:0]    in_wa,
   input  logic [LANES-1:0]   in_be,
   input  logic [8*LANES-1:0] in_data,
   output logic               vld,
   output logic [WA_W-1:0]    wa,
   output logic [LANES-1:0]   be,
   output logic [8*LANES-1:0] data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld  <= 1'b0;
         wa   <= '0;
         be   <= '0;
         data <= '0;
      end else if (load) begin
         vld  <= 1'b1;
         wa   <= in_wa;
         be   <= in_be;
         data <= in_data;
      end
   end
endmodule

// File: rtl/wbuf_merge.sv
module wbuf_merge #(
   parameter int LANES = 4
) (
   input  logic [LANES-1:0]   ovr_be,
   input  logic [8*LANES-1:0] ovr_data,
   input  logic [8*LANES-1:0] base,
   output logic [8*LANES-1:0] merged
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign merged[8*i +: 8] = ovr_be[i] ? ovr_data[8*i +: 8] : base[8*i +: 8];
   end
endmodule

// File: rtl/sram_wbuf.sv
module sram_wbuf #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   cpu_req,
   input  logic                                   cpu_we,
   input  logic [ADDR_W-1:0]                      cpu_addr,
   input  logic [1:0]                             cpu_size,
   input  logic [DATA_W-1:0]                      cpu_wdata,
   output logic [DATA_W-1:0]                      cpu_rdata,
   output logic                                   sram_en,
   output logic                                   sram_we,
   output logic [ADDR_W-$clog2(DATA_W/8)-1:0]     sram_addr,
   output logic [DATA_W/8-1:0]                    sram_be,
   output logic [DATA_W-1:0]                      sram_wdata,
   input  logic [DATA_W-1:0]                      sram_rdata
);
   localparam int LANES = DATA_W / 8;
   localparam int OFF_W = $clog2(LANES);
   localparam int WA_W  = ADDR_W - OFF_W;

   if (DATA_W % 8 != 0 || LANES < 2 || (1 << OFF_W) != LANES) begin : g_bad_width
      $error("sram_wbuf: DATA_W must be a power-of-two number of bytes, at least 16 bits");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("sram_wbuf: ADDR_W too small for DATA_W");
   end

   logic               wr_acc, rd_acc;
   logic [WA_W-1:0]    req_wa;
   logic [LANES-1:0]   new_be;
   logic [DATA_W-1:0]  new_data;
   logic               b_vld;
   logic [WA_W-1:0]    b_wa;
   logic [LANES-1:0]   b_be;
   logic [DATA_W-1:0]  b_data;
   logic [LANES-1:0]   snap_be;
   logic [DATA_W-1:0]  snap_data;

   assign wr_acc = cpu_req & cpu_we;
   assign rd_acc = cpu_req & ~cpu_we;
   assign req_wa = cpu_addr[ADDR_W-1:OFF_W];

   wbuf_lane_map #(.DATA_W(DATA_W)) u_map (
      .off       (cpu_addr[OFF_W-1:0]),
      .size      (cpu_size),
      .wdata     (cpu_wdata),
      .be        (new_be),
      .lane_data (new_data)
   );

   wbuf_hold #(.WA_W(WA_W), .LANES(LANES)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (wr_acc),
      .in_wa   (req_wa),
      .in_be   (new_be),
      .in_data (new_data),
      .vld     (b_vld),
      .wa      (b_wa),
      .be      (b_be),
      .data    (b_data)
   );

   // the parked entry leaves only when a new store replaces it
   always_comb begin
      sram_en    = rd_acc | (wr_acc & b_vld);
      sram_we    = wr_acc & b_vld;
      sram_addr  = wr_acc ? b_wa : req_wa;
      sram_be    = wr_acc ? b_be : '0;
      sram_wdata = b_data;
   end

   // snapshot of the parked bytes at read time, applied when data returns
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_be   <= '0;
         snap_data <= '0;
      end else if (rd_acc) begin
         snap_be   <= (b_vld && b_wa == req_wa) ? b_be : '0;
         snap_data <= b_data;
      end
   end

   wbuf_merge #(.LANES(LANES)) u_merge (
      .ovr_be   (snap_be),
      .ovr_data (snap_data),
      .base     (sram_rdata),
      .merged   (cpu_rdata)
   );
endmodule

// File: rtl/sram_wbuf_chk.sv
module sram_wbuf_chk #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32
) (
   input logic                               clk,
   input logic                               rst_n,
   input logic                               cpu_req,
   input logic                               cpu_we,
   input logic [ADDR_W-1:0]                  cpu_addr,
   input logic                               sram_en,
   input logic                               sram_we,
   input logic [ADDR_W-$clog2(DATA_W/8)-1:0] sram_addr,
   input logic [DATA_W/8-1:0]                sram_be
);
   localparam int LANES = DATA_W / 8;
   localparam int OFF_W = $clog2(LANES);
   localparam int WA_W  = ADDR_W - OFF_W;

   logic            seen;
   logic [WA_W-1:0] last_wa;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen    <= 1'b0;
         last_wa <= '0;
      end else if (cpu_req && cpu_we) begin
         seen    <= 1'b1;
         last_wa <= cpu_addr[ADDR_W-1:OFF_W];
      end
   end

   p_first_write_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_we && !seen) |-> !sram_we);

   p_commit_prev_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_we && seen) |-> (sram_we && sram_en && sram_addr == last_wa));

   p_lane_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sram_we |-> ($countones(sram_be) == 1 || $countones(sram_be) == 2 ||
                   $countones(sram_be) == LANES));

   p_read_port_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_we) |-> (sram_en && !sram_we && sram_addr == cpu_addr[ADDR_W-1:OFF_W]));

   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_req |-> !sram_en);
endmodule

bind sram_wbuf sram_wbuf_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_req   (cpu_req),
   .cpu_we    (cpu_we),
   .cpu_addr  (cpu_addr),
   .sram_en   (sram_en),
   .sram_we   (sram_we),
   .sram_addr (sram_addr),
   .sram_be   (sram_be)
);

// File: tb/sim_sram_wbuf.sv
module sim_sram_wbuf;
   localparam int AW = 10;
   localparam int NW = 256;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [1:0]  cpu_size = '0;
   logic [31:0] cpu_wdata = '0;
   logic [31:0] cpu_rdata;
   logic        sram_en, sram_we;
   logic [AW-3:0] sram_addr;
   logic [3:0]  sram_be;
   logic [31:0] sram_wdata;
   logic [31:0] sram_rdata = '0;

   sram_wbuf #(.ADDR_W(AW), .DATA_W(32)) u0 (.*);

   always #4 clk = ~clk;

   // environment: synchronous SRAM
   logic [31:0] mem [NW];
   always @(posedge clk) begin
      if (sram_en) begin
         if (sram_we) begin
            for (int i = 0; i < 4; i++)
               if (sram_be[i]) mem[sram_addr][8*i +: 8] <= sram_wdata[8*i +: 8];
         end else begin
            sram_rdata <= mem[sram_addr];
         end
      end
   end

   // reference model
   logic [31:0] ref_mem [NW];
   bit          b_vld;
   int          b_wa;
   logic [3:0]  b_be;
   logic [31:0] b_data;
   bit          rd_pend;
   logic [31:0] rd_exp;
   string       rd_tag;
   int          total = 0, bad = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] be_of(input int addr, input int sz);
      case (sz)
         0: be_of = 4'b0001 << (addr & 3);
         1: be_of = (addr & 2) ? 4'b1100 : 4'b0011;
         default: be_of = 4'b1111;
      endcase
   endfunction

   function automatic logic [31:0] lanes_of(input int addr, input int sz, input logic [31:0] d);
      int sh;
      sh = (sz == 0) ? (addr & 3) : (sz == 1) ? (addr & 2) : 0;
      lanes_of = d << (8 * sh);
   endfunction

   function automatic logic [31:0] mask32(input logic [3:0] be);
      for (int i = 0; i < 4; i++) mask32[8*i +: 8] = be[i] ? 8'hFF : 8'h00;
   endfunction

   task automatic settle_read();
      if (rd_pend) chk(cpu_rdata == rd_exp, rd_tag, cpu_rdata, rd_exp);
      rd_pend = 0;
   endtask

   task automatic op(input bit req, input bit we, input int addr, input int sz, input logic [31:0] d);
      logic [31:0] m;
      @(negedge clk);
      settle_read();
      cpu_req = req; cpu_we = we; cpu_addr = AW'(addr); cpu_size = 2'(sz); cpu_wdata = d;
      #1;
      if (req && we) begin
         chk(sram_we == b_vld, b_vld ? "R3" : "R1", 32'(sram_we), 32'(b_vld));
         if (b_vld) begin
            m = mask32(b_be);
            chk(sram_addr == (AW-2)'(b_wa), "R3", 32'(sram_addr), 32'(b_wa));
            chk(sram_be == b_be, "R2", 32'(sram_be), 32'(b_be));
            chk((sram_wdata & m) == (b_data & m), "R2", sram_wdata & m, b_data & m);
            ref_mem[b_wa] = (ref_mem[b_wa] & ~m) | (b_data & m);
         end
         b_vld = 1; b_wa = addr >> 2; b_be = be_of(addr, sz); b_data = lanes_of(addr, sz, d);
      end else if (req) begin
         chk(sram_en && !sram_we && sram_addr == (AW-2)'(addr >> 2), "R5", 32'(sram_addr), 32'(addr >> 2));
         m = (b_vld && b_wa == (addr >> 2)) ? mask32(b_be) : 32'h0;
         rd_exp = (ref_mem[addr >> 2] & ~m) | (b_data & m);
         rd_tag = (m != 0) ? "R6" : "R7";
         rd_pend = 1;
      end else begin
         chk(!sram_en, "R9", 32'(sram_en), 32'h0);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      settle_read();
      cpu_req = 0; rst_n = 0;
      b_vld = 0;
      @(negedge clk);
      rst_n = 1;
   endtask

   initial begin
      for (int i = 0; i < NW; i++) begin
         mem[i]     = 32'hA0B0C0D0 ^ (32'(i) * 32'h01010101);
         ref_mem[i] = 32'hA0B0C0D0 ^ (32'(i) * 32'h01010101);
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      rst_n = 1;
      #1;
      chk(!sram_en, "R1", 32'(sram_en), 32'h0);
      op(0, 0, 0, 0, 0);                       // R9 idle
      op(1, 1, 16, 0, 32'h11);                 // R1 first write, no commit
      op(1, 0, 16, 2, 0);                      // R6 hit, byte lane 0
      op(1, 1, 17, 0, 32'h22);                 // R2 lane 1, commits previous
      op(1, 1, 18, 0, 32'h33);                 // R2 lane 2
      op(1, 1, 19, 0, 32'h44);                 // R2 lane 3
      op(1, 0, 16, 2, 0);                      // R6 hit lane 3 over committed lanes
      op(1, 1, 20, 1, 32'h5566);               // R2 half low
      op(1, 1, 23, 1, 32'h7788);               // R2 half high, bit 0 ignored
      op(1, 0, 20, 2, 0);                      // R6
      op(1, 0, 40, 2, 0);                      // R7 miss
      op(1, 1, 24, 2, 32'hDEADBEEF);           // R4 back-to-back
      op(1, 1, 28, 3, 32'hCAFEF00D);           // R2 code 3 as word
      op(1, 1, 32, 2, 32'h01234567);
      op(0, 0, 0, 0, 0);                       // R9 idle while parked
      op(1, 0, 28, 0, 0);                      // R7 committed word
      op(1, 0, 32, 0, 0);                      // R6 still parked
      op(1, 1, 36, 0, 32'h9A);
      do_reset();                              // R8 drop parked byte
      op(1, 0, 36, 2, 0);                      // R8/R7 old SRAM data
      op(1, 1, 44, 2, 32'h0BADC0DE);           // R1/R8 nothing committed
      op(1, 1, 200, 2, 32'h0);                 // dummy flush
      op(1, 0, 44, 2, 0);
      begin
         logic [31:0] r = 32'h1ACE1;
         for (int n = 0; n < 150; n++) begin
            r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
            op(r[7:5] != 0, r[4], int'(r[12:8]), int'(r[14:13]), r ^ 32'h5A5A5A5A);
         end
      end
      op(0, 0, 0, 0, 0);
      @(negedge clk);
      settle_read();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule